// File: doc/BRIEF.md
# Wake and SMI Event Aggregator

This block gathers wake events from sixteen sources and reduces them to two active-low requests: a power-management event (PME) line and a group system-management interrupt (SMI). The sources are eight general-purpose pins, a consumer IR receiver, two serial ring indicates, keyboard, mouse, a modem ring, a real-time-clock alarm and a device-interrupt source. Each source has a sticky status bit. The bit is set on a rising edge of the source, whether or not that source is enabled. Firmware clears a status bit by writing 1 to it.

Two separate enable sets decide which pending events reach the outputs. The PME enables live in a battery-backed domain and survive an ordinary system reset. A global enable gates the PME line. The SMI group can be sent either to a dedicated pin or to a serial IRQ slot request, and it can also be folded into the PME request. All state is reached through a byte-wide register port with a 4-bit offset.

Register offsets: status 0x0 (sources 7..0) and 0x1 (sources 15..8); SMI configuration 0x4 and 0x5; control 0x8; PME enables 0xE (sources 7..0) and 0xF (sources 15..8). Source numbering: bits 7..0 are general-purpose pins 7..0. Bit 8 is consumer IR, 9 is serial ring 2, 10 is serial ring 1, 11 is keyboard, 12 is mouse, 13 is modem ring, 14 is RTC alarm and 15 is the device interrupt. In each high byte, register bit n stands for source 8+n.

Top module: `wake_smi_agg`

## Requirements
- R1: Each status bit is set on the clock edge that first samples its source high after a low sample, regardless of any enable. A source already high while a reset is held does not set its bit after reset.
- R2: Writing 1 to a status bit at offset 0x0/0x1 clears it, and writing 0 leaves it unchanged. If a new rising edge of a source lands on the same edge as a clear of its bit, the bit stays set.
- R3: pme_n_o is driven low one clock after the status bits, the enables and the global enable (offset 0x8 bit 0) make a PME request. It returns high one clock after the request goes away.
- R4: The PME enable registers at 0xE and 0xF can be read and written. A pending status bit whose PME enable is 0 does not pull pme_n_o low.
- R5: The PME enable registers are cleared only by vbat_rst. rst leaves them unchanged, and no write takes effect while rst is high.
- R6: The SMI group is the OR of the pending status bits of sources 13..0 that are enabled by SMI configuration bits 0x4[7:0] (sources 7..0) and 0x5[5:0] (sources 13..8).
- R7: With 0x5 bit 7 equal to 0, the active SMI group drives smi_pin_n_o low. With bit 7 equal to 1, it drives smi_ser_n_o low instead. The output that is not selected stays high. Both are registered one clock after the status bits.
- R8: With 0x5 bit 6 set and the global enable set, an active SMI group also drives pme_n_o low.
- R9: rd_data_o is loaded one clock after rd_i and holds between reads. Offsets 0x2, 0x3, 0x6, 0x7 and 0x9 to 0xD read as 0x00.
- R10: rst or vbat_rst clears the status, SMI configuration and control registers and drives all three outputs high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous system reset, active high |
| vbat_rst | input | 1 | Synchronous battery-domain power-on reset, active high |
| src_i | input | 16 | Wake source levels, numbered as above |
| wr_i | input | 1 | Single-cycle write strobe |
| rd_i | input | 1 | Single-cycle read strobe |
| addr_i | input | 4 | Register offset |
| wdata_i | input | 8 | Write data |
| rd_data_o | output | 8 | Registered read data |
| pme_n_o | output | 1 | PME request, active low |
| smi_pin_n_o | output | 1 | Group SMI on the dedicated pin, active low |
| smi_ser_n_o | output | 1 | Group SMI request for serial IRQ slot 2, active low |

## Verification
The bench goes after several corner cases.

- A status clear written on the same edge as a new rising edge: a design that let the clear win would silently lose a wake event.
- A source held high across reset: a design with a badly reset edge detector would report a phantom event.
- A system reset between configuration steps: a design that put the PME enables in the system domain would lose its wake configuration on every ordinary reset.
- Toggling the routing bit, the fold bit and the global enable while an SMI event is pending: a wrong route would assert both SMI outputs or neither, and a wrong gate would fire PME when it is disabled.

// File: rtl/wake_agg_pkg.sv
package wake_agg_pkg;
  // Register offsets; byte k of a multi-byte group sits at base + k
  localparam int OFF_STAT = 0;
  localparam int OFF_SMI  = 4;
  localparam int OFF_CTRL = 8;
  localparam int OFF_PME  = 14;
  // Control register field
  localparam int CTRL_GLOB_BIT = 0;
endpackage

// File: rtl/wake_status_bank.sv
module wake_status_bank #(
  parameter int NUM_SRC = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [NUM_SRC-1:0] clr_mask_i,
  output logic [NUM_SRC-1:0] stat_o,
  output logic [NUM_SRC-1:0] rise_o
);
  logic [NUM_SRC-1:0] prev_q;
  logic [NUM_SRC-1:0] stat_q;

  // Edge history follows the source during reset so a level held
  // through reset is not seen as a new event.
  always_ff @(posedge clk) begin
    prev_q <= src_i;
  end

  generate
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
      assign rise_o[i] = src_i[i] & ~prev_q[i];
      always_ff @(posedge clk) begin
        if (rst) begin
          stat_q[i] <= 1'b0;
        end else if (rise_o[i]) begin
          stat_q[i] <= 1'b1;           // a new event beats a clear
        end else if (clr_mask_i[i]) begin
          stat_q[i] <= 1'b0;
        end
      end
    end
  endgenerate

  assign stat_o = stat_q;
endmodule

// File: rtl/wake_cfg_regs.sv
module wake_cfg_regs
  import wake_agg_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 8,
  parameter int NUM_SRC = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               vbat_rst,
  input  logic               wr_i,
  input  logic               rd_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic [NUM_SRC-1:0] stat_i,
  output logic [NUM_SRC-1:0] stat_clr_o,
  output logic [NUM_SRC-1:0] pme_en_o,
  output logic [NUM_SRC-1:0] smi_cfg_o,
  output logic               glob_o,
  output logic [DATA_W-1:0]  rd_data_o
);
  localparam int NB = NUM_SRC / DATA_W;

  logic              sys_rst;
  logic [NUM_SRC-1:0] pme_q;
  logic [NUM_SRC-1:0] smi_q;
  logic              glob_q;
  logic [NB-1:0]     hit_stat;
  logic [NB-1:0]     hit_pme;
  logic [NB-1:0]     hit_smi;
  logic              hit_ctrl;
  logic [DATA_W-1:0] rd_mux;
  logic [DATA_W-1:0] rd_q;

  assign sys_rst  = rst | vbat_rst;
  assign hit_ctrl = (addr_i == ADDR_W'(OFF_CTRL));

  generate
    for (genvar k = 0; k < NB; k++) begin : g_byte
      assign hit_stat[k] = (addr_i == ADDR_W'(OFF_STAT + k));
      assign hit_pme[k]  = (addr_i == ADDR_W'(OFF_PME + k));
      assign hit_smi[k]  = (addr_i == ADDR_W'(OFF_SMI + k));

      // Write-one-to-clear mask toward the status bank
      assign stat_clr_o[k*DATA_W +: DATA_W] =
        (wr_i && hit_stat[k]) ? wdata_i : '0;

      // Battery-domain enables: only the battery reset clears them
      always_ff @(posedge clk) begin
        if (vbat_rst) begin
          pme_q[k*DATA_W +: DATA_W] <= '0;
        end else if (!rst && wr_i && hit_pme[k]) begin
          pme_q[k*DATA_W +: DATA_W] <= wdata_i;
        end
      end

      // System-domain SMI configuration
      always_ff @(posedge clk) begin
        if (sys_rst) begin
          smi_q[k*DATA_W +: DATA_W] <= '0;
        end else if (wr_i && hit_smi[k]) begin
          smi_q[k*DATA_W +: DATA_W] <= wdata_i;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (sys_rst) begin
      glob_q <= 1'b0;
    end else if (wr_i && hit_ctrl) begin
      glob_q <= wdata_i[CTRL_GLOB_BIT];
    end
  end

  always_comb begin
    rd_mux = '0;
    for (int k = 0; k < NB; k++) begin
      if (hit_stat[k]) rd_mux = stat_i[k*DATA_W +: DATA_W];
      if (hit_pme[k])  rd_mux = pme_q[k*DATA_W +: DATA_W];
      if (hit_smi[k])  rd_mux = smi_q[k*DATA_W +: DATA_W];
    end
    if (hit_ctrl) rd_mux[CTRL_GLOB_BIT] = glob_q;
  end

  always_ff @(posedge clk) begin
    if (sys_rst) begin
      rd_q <= '0;
    end else if (rd_i) begin
      rd_q <= rd_mux;
    end
  end

  assign pme_en_o  = pme_q;
  assign smi_cfg_o = smi_q;
  assign glob_o    = glob_q;
  assign rd_data_o = rd_q;
endmodule

// File: rtl/wake_out_merge.sv
module wake_out_merge #(
  parameter int NUM_SRC = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] stat_i,
  input  logic [NUM_SRC-1:0] pme_en_i,
  input  logic [NUM_SRC-1:0] smi_cfg_i,
  input  logic               glob_i,
  output logic               pme_n_o,
  output logic               smi_pin_n_o,
  output logic               smi_ser_n_o
);
  // Top two configuration bits are controls; the rest are SMI enables
  localparam int ROUTE_BIT = NUM_SRC - 1;
  localparam int FOLD_BIT  = NUM_SRC - 2;
  localparam int NUM_SMI   = NUM_SRC - 2;

  logic pme_hit;
  logic smi_grp;
  logic pme_req;

  assign pme_hit = |(stat_i & pme_en_i);
  assign smi_grp = |(stat_i[NUM_SMI-1:0] & smi_cfg_i[NUM_SMI-1:0]);
  assign pme_req = glob_i & (pme_hit | (smi_cfg_i[FOLD_BIT] & smi_grp));

  always_ff @(posedge clk) begin
    if (rst) begin
      pme_n_o     <= 1'b1;
      smi_pin_n_o <= 1'b1;
      smi_ser_n_o <= 1'b1;
    end else begin
      pme_n_o     <= ~pme_req;
      smi_pin_n_o <= ~(smi_grp & ~smi_cfg_i[ROUTE_BIT]);
      smi_ser_n_o <= ~(smi_grp &  smi_cfg_i[ROUTE_BIT]);
    end
  end
endmodule

// File: rtl/wake_smi_agg.sv
module wake_smi_agg #(
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 8,
  parameter int NUM_SRC = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               vbat_rst,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               wr_i,
  input  logic               rd_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rd_data_o,
  output logic               pme_n_o,
  output logic               smi_pin_n_o,
  output logic               smi_ser_n_o
);
  logic               any_rst;
  logic [NUM_SRC-1:0] stat_w;
  logic [NUM_SRC-1:0] rise_w;
  logic [NUM_SRC-1:0] clr_w;
  logic [NUM_SRC-1:0] pme_en_w;
  logic [NUM_SRC-1:0] smi_cfg_w;
  logic               pme_glob_w;

  assign any_rst = rst | vbat_rst;

  wake_status_bank #(.NUM_SRC(NUM_SRC)) u_stat (
    .clk        (clk),
    .rst        (any_rst),
    .src_i      (src_i),
    .clr_mask_i (clr_w),
    .stat_o     (stat_w),
    .rise_o     (rise_w)
  );

  wake_cfg_regs #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .NUM_SRC(NUM_SRC)
  ) u_cfg (
    .clk        (clk),
    .rst        (rst),
    .vbat_rst   (vbat_rst),
    .wr_i       (wr_i),
    .rd_i       (rd_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .stat_i     (stat_w),
    .stat_clr_o (clr_w),
    .pme_en_o   (pme_en_w),
    .smi_cfg_o  (smi_cfg_w),
    .glob_o     (pme_glob_w),
    .rd_data_o  (rd_data_o)
  );

  wake_out_merge #(.NUM_SRC(NUM_SRC)) u_out (
    .clk         (clk),
    .rst         (any_rst),
    .stat_i      (stat_w),
    .pme_en_i    (pme_en_w),
    .smi_cfg_i   (smi_cfg_w),
    .glob_i      (pme_glob_w),
    .pme_n_o     (pme_n_o),
    .smi_pin_n_o (smi_pin_n_o),
    .smi_ser_n_o (smi_ser_n_o)
  );
endmodule

// File: rtl/wake_smi_agg_chk.sv
module wake_smi_agg_chk
  import wake_agg_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 8,
  parameter int NUM_SRC = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               vbat_rst,
  input logic               wr_i,
  input logic               rd_i,
  input logic [ADDR_W-1:0]  addr_i,
  input logic [DATA_W-1:0]  rd_data_o,
  input logic               pme_n_o,
  input logic               smi_pin_n_o,
  input logic               smi_ser_n_o,
  input logic [NUM_SRC-1:0] stat,
  input logic [NUM_SRC-1:0] rise,
  input logic [NUM_SRC-1:0] pme_en,
  input logic               glob
);
  localparam int NB = NUM_SRC / DATA_W;

  logic any_rst;
  logic stat_wr;
  logic mapped;

  assign any_rst = rst | vbat_rst;
  assign stat_wr = wr_i && (int'(addr_i) < OFF_STAT + NB);
  assign mapped  = (int'(addr_i) < OFF_STAT + NB) ||
                   ((int'(addr_i) >= OFF_SMI) && (int'(addr_i) < OFF_SMI + NB)) ||
                   (int'(addr_i) == OFF_CTRL) ||
                   ((int'(addr_i) >= OFF_PME) && (int'(addr_i) < OFF_PME + NB));

  // R1
  edge_sets_status_chk: assert property (@(posedge clk) disable iff (any_rst)
    (|rise) |=> ((stat & $past(rise)) == $past(rise)));

  // R2
  status_sticky_chk: assert property (@(posedge clk) disable iff (any_rst)
    (!$past(any_rst) && (($past(stat) & ~stat) != '0)) |-> $past(stat_wr));

  // R3
  pme_needs_glob_chk: assert property (@(posedge clk) disable iff (any_rst)
    !pme_n_o |-> $past(glob));

  // R5
  pme_en_keeps_chk: assert property (@(posedge clk) disable iff (vbat_rst)
    rst |=> $stable(pme_en));

  // R7
  smi_one_route_chk: assert property (@(posedge clk) disable iff (any_rst)
    $onehot0({~smi_pin_n_o, ~smi_ser_n_o}));

  // R9
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (any_rst)
    (rd_i && !mapped) |=> (rd_data_o == '0));
endmodule

bind wake_smi_agg wake_smi_agg_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .NUM_SRC(NUM_SRC)
) chk_i (
  .clk         (clk),
  .rst         (rst),
  .vbat_rst    (vbat_rst),
  .wr_i        (wr_i),
  .rd_i        (rd_i),
  .addr_i      (addr_i),
  .rd_data_o   (rd_data_o),
  .pme_n_o     (pme_n_o),
  .smi_pin_n_o (smi_pin_n_o),
  .smi_ser_n_o (smi_ser_n_o),
  .stat        (stat_w),
  .rise        (rise_w),
  .pme_en      (pme_en_w),
  .glob        (pme_glob_w)
);

// File: tb/wake_smi_agg_tb_top.sv
module wake_smi_agg_tb_top;
  typedef struct packed {
    logic [3:0]  req;
    logic [15:0] src;
    logic        wr;
    logic        rd;
    logic [3:0]  addr;
    logic [7:0]  wdata;
    logic [7:0]  exp_rd;
    logic        exp_pme;
    logic        exp_pin;
    logic        exp_ser;
  } vec_t;

  localparam int NV = 23;
  // req, src, wr, rd, addr, wdata, exp_rd, pme_n, pin_n, ser_n
  localparam vec_t VECS [NV] = '{
    '{4'd3, 16'h0000, 1'b1, 1'b0, 4'h8, 8'h01, 8'h00, 1'b1, 1'b1, 1'b1}, // R3 global on
    '{4'd4, 16'h0000, 1'b1, 1'b0, 4'hE, 8'h01, 8'h00, 1'b1, 1'b1, 1'b1}, // R4 enable gp0
    '{4'd3, 16'h0001, 1'b0, 1'b0, 4'h0, 8'h00, 8'h00, 1'b0, 1'b1, 1'b1}, // R3 gp0 fires
    '{4'd1, 16'h0001, 1'b0, 1'b1, 4'h0, 8'h00, 8'h01, 1'b0, 1'b1, 1'b1}, // R1 status read
    '{4'd2, 16'h0001, 1'b1, 1'b0, 4'h0, 8'h00, 8'h00, 1'b0, 1'b1, 1'b1}, // R2 write 0 no effect
    '{4'd2, 16'h0001, 1'b1, 1'b0, 4'h0, 8'h01, 8'h00, 1'b1, 1'b1, 1'b1}, // R2 W1C
    '{4'd4, 16'h0003, 1'b0, 1'b0, 4'h0, 8'h00, 8'h00, 1'b1, 1'b1, 1'b1}, // R4 disabled source
    '{4'd1, 16'h0003, 1'b0, 1'b1, 4'h0, 8'h00, 8'h02, 1'b1, 1'b1, 1'b1}, // R1 recorded anyway
    '{4'd6, 16'h0003, 1'b1, 1'b0, 4'h4, 8'h02, 8'h00, 1'b1, 1'b0, 1'b1}, // R6 SMI to pin
    '{4'd7, 16'h0003, 1'b1, 1'b0, 4'h5, 8'h80, 8'h00, 1'b1, 1'b1, 1'b0}, // R7 route to serial
    '{4'd8, 16'h0003, 1'b1, 1'b0, 4'h5, 8'hC0, 8'h00, 1'b0, 1'b1, 1'b0}, // R8 fold into PME
    '{4'd3, 16'h0003, 1'b1, 1'b0, 4'h8, 8'h00, 8'h00, 1'b1, 1'b1, 1'b0}, // R3 global off
    '{4'd3, 16'h0003, 1'b1, 1'b0, 4'h8, 8'h01, 8'h00, 1'b0, 1'b1, 1'b0}, // R3 global on
    '{4'd6, 16'h0003, 1'b0, 1'b1, 4'h5, 8'h00, 8'hC0, 1'b0, 1'b1, 1'b0}, // R6 config readback
    '{4'd2, 16'h0003, 1'b1, 1'b0, 4'h0, 8'h02, 8'h00, 1'b1, 1'b1, 1'b1}, // R2 clear gp1
    '{4'd9, 16'h0003, 1'b0, 1'b1, 4'h3, 8'h00, 8'h00, 1'b1, 1'b1, 1'b1}, // R9 unmapped
    '{4'd4, 16'h0003, 1'b0, 1'b1, 4'hE, 8'h00, 8'h01, 1'b1, 1'b1, 1'b1}, // R4 readback
    '{4'd1, 16'h4003, 1'b0, 1'b0, 4'h0, 8'h00, 8'h00, 1'b1, 1'b1, 1'b1}, // R1 RTC alarm
    '{4'd1, 16'h4003, 1'b0, 1'b1, 4'h1, 8'h00, 8'h40, 1'b1, 1'b1, 1'b1}, // R1 high byte
    '{4'd4, 16'h4003, 1'b1, 1'b0, 4'hF, 8'h40, 8'h00, 1'b0, 1'b1, 1'b1}, // R4 enable RTC
    '{4'd2, 16'h4003, 1'b1, 1'b0, 4'h1, 8'h40, 8'h00, 1'b1, 1'b1, 1'b1}, // R2 clear RTC
    '{4'd6, 16'h4803, 1'b0, 1'b0, 4'h0, 8'h00, 8'h00, 1'b1, 1'b1, 1'b1}, // R6 kbd not enabled
    '{4'd6, 16'h4803, 1'b1, 1'b0, 4'h5, 8'h08, 8'h00, 1'b1, 1'b0, 1'b1}  // R6 kbd SMI to pin
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        vbat_rst = 1'b1;
  logic [15:0] src_i = '0;
  logic        wr_i = 1'b0;
  logic        rd_i = 1'b0;
  logic [3:0]  addr_i = '0;
  logic [7:0]  wdata_i = '0;
  logic [7:0]  rd_data_o;
  logic        pme_n_o;
  logic        smi_pin_n_o;
  logic        smi_ser_n_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  wake_smi_agg dut_i (
    .clk         (clk),
    .rst         (rst),
    .vbat_rst    (vbat_rst),
    .src_i       (src_i),
    .wr_i        (wr_i),
    .rd_i        (rd_i),
    .addr_i      (addr_i),
    .wdata_i     (wdata_i),
    .rd_data_o   (rd_data_o),
    .pme_n_o     (pme_n_o),
    .smi_pin_n_o (smi_pin_n_o),
    .smi_ser_n_o (smi_ser_n_o)
  );

  task automatic check(input string tag, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic check_outs(input string tag, input logic p, input logic a,
                            input logic s);
    check(tag, "pme_n_o", {7'd0, pme_n_o}, {7'd0, p});
    check(tag, "smi_pin_n_o", {7'd0, smi_pin_n_o}, {7'd0, a});
    check(tag, "smi_ser_n_o", {7'd0, smi_ser_n_o}, {7'd0, s});
  endtask

  // One bus/source step, then settle two more cycles before sampling
  task automatic drive(input logic [15:0] s, input logic w, input logic r,
                       input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    src_i = s; wr_i = w; rd_i = r; addr_i = a; wdata_i = d;
    @(negedge clk);
    wr_i = 1'b0; rd_i = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic pulse_reset(input logic sys, input logic bat);
    @(negedge clk);
    rst = sys; vbat_rst = bat;
    repeat (2) @(negedge clk);
    rst = 1'b0; vbat_rst = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0; vbat_rst = 1'b0;
    repeat (2) @(negedge clk);

    // R10 reset state
    check_outs("R10 reset", 1'b1, 1'b1, 1'b1);
    drive(16'h0000, 1'b0, 1'b1, 4'h0, 8'h00);
    check("R10 reset", "status lo", rd_data_o, 8'h00);
    drive(16'h0000, 1'b0, 1'b1, 4'h8, 8'h00);
    check("R10 reset", "ctrl", rd_data_o, 8'h00);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d step %0d", VECS[i].req, i);
      drive(VECS[i].src, VECS[i].wr, VECS[i].rd, VECS[i].addr, VECS[i].wdata);
      check_outs(tag, VECS[i].exp_pme, VECS[i].exp_pin, VECS[i].exp_ser);
      if (VECS[i].rd) check(tag, "rd_data_o", rd_data_o, VECS[i].exp_rd);
    end

    // R5 / R10: system reset keeps PME enables, clears the rest
    pulse_reset(1'b1, 1'b0);
    check_outs("R10 sys reset", 1'b1, 1'b1, 1'b1);
    drive(16'h4803, 1'b0, 1'b1, 4'hE, 8'h00);
    check("R5 sys reset", "pme en lo", rd_data_o, 8'h01);
    drive(16'h4803, 1'b0, 1'b1, 4'hF, 8'h00);
    check("R5 sys reset", "pme en hi", rd_data_o, 8'h40);
    drive(16'h4803, 1'b0, 1'b1, 4'h8, 8'h00);
    check("R10 sys reset", "ctrl", rd_data_o, 8'h00);
    drive(16'h4803, 1'b0, 1'b1, 4'h5, 8'h00);
    check("R10 sys reset", "smi hi", rd_data_o, 8'h00);
    // R1: sources held high through reset give no event
    drive(16'h4803, 1'b0, 1'b1, 4'h1, 8'h00);
    check("R1 held source", "status hi", rd_data_o, 8'h00);
    drive(16'h4803, 1'b0, 1'b1, 4'h0, 8'h00);
    check("R1 held source", "status lo", rd_data_o, 8'h00);

    // R2: rising edge and clear on the same edge, edge wins
    drive(16'h4807, 1'b1, 1'b0, 4'h0, 8'h04);
    drive(16'h4807, 1'b0, 1'b1, 4'h0, 8'h00);
    check("R2 collision", "status lo", rd_data_o, 8'h04);

    // R9: read data holds between reads
    drive(16'h4807, 1'b1, 1'b0, 4'h0, 8'h04);
    check("R9 hold", "rd_data_o", rd_data_o, 8'h04);

    // R5: battery reset clears the PME enables
    pulse_reset(1'b0, 1'b1);
    drive(16'h4807, 1'b0, 1'b1, 4'hE, 8'h00);
    check("R5 vbat reset", "pme en lo", rd_data_o, 8'h00);
    drive(16'h4807, 1'b0, 1'b1, 4'hF, 8'h00);
    check("R5 vbat reset", "pme en hi", rd_data_o, 8'h00);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule